// File: doc/BRIEF.md
# Clock Page Replacement Selector

This block picks a victim frame when a memory manager needs to evict a page. It keeps two flags per frame: a recently-used flag and a modified flag. Every access to a frame sets its recently-used flag, and a write access also sets its modified flag. A persistent sweep pointer remembers where the last victim was taken. When a replacement is requested, the pointer steps forward one frame per clock, wrapping around the table. Each frame it passes over loses its recently-used flag, which gives that frame a second chance. The sweep stops at the first frame that qualifies as a victim.

Two policies are available, chosen per request. The loose policy takes any frame whose recently-used flag is clear. The strict policy also requires that the frame is unmodified. If the strict policy finds no clean candidate within two full laps, it falls back to the first unused frame it met and raises a flag that says the victim holds modified data. The chosen frame's modified flag is cleared, because the incoming page arrives clean.

Top module: `clock_victim_sel`

## Requirements
- R1: After reset all recently-used and modified flags are 0, `busy` and `victim_done` are low, and the sweep pointer rests on the last frame (FRAMES-1), so the first search examines frame 0 first.
- R2: An access with `acc_idx` below FRAMES sets that frame's recently-used flag at the next clock edge; if `acc_write` is 1 it also sets the frame's modified flag.
- R3: In loose mode (`strict_clean`=0), the victim is the first frame, starting at pointer+1 and wrapping modulo FRAMES, whose recently-used flag is 0. Every frame examined before it has its recently-used flag cleared.
- R4: The pointer is left on the chosen victim, and the next search begins at the frame after it.
- R5: One frame is examined per clock. If E frames are examined, `victim_done` rises on the (E+1)-th rising edge after the edge that accepted the request. In loose mode with no concurrent accesses, E is at most FRAMES+1.
- R6: In strict mode (`strict_clean`=1), the victim is the first frame with both flags 0, and `victim_dirty` is 0.
- R7: In strict mode, if 2*FRAMES examinations find no frame with both flags 0, the victim is the first frame seen with a clear recently-used flag, and `victim_dirty` is 1.
- R8: An access that lands in the same cycle as the sweep clearing that frame's flag wins, so the flag stays set.
- R9: When a victim is chosen, its modified flag is cleared in the cycle `victim_done` is high, unless a write access to that frame arrived at the same edge.
- R10: `busy` is high from the edge after a request is accepted until the edge that raises `victim_done`. `victim_done` is a one-cycle strobe. A `repl_req` seen while busy is ignored.
- R11: In loose mode, `victim_dirty` reports the victim's modified flag as it was when the frame was chosen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | Access event for frame `acc_idx` |
| acc_idx | input | $clog2(FRAMES) | Frame index of the access |
| acc_write | input | 1 | Access is a write (also sets the modified flag) |
| repl_req | input | 1 | Start a victim search (accepted only when idle) |
| strict_clean | input | 1 | Policy for this request: 1 = unused and clean, 0 = unused |
| busy | output | 1 | Search in progress |
| victim_done | output | 1 | One-cycle strobe: victim is valid |
| victim_idx | output | $clog2(FRAMES) | Chosen frame |
| victim_dirty | output | 1 | Chosen frame held modified data |

## Verification
The hardest case to reach from the ports is an access that arrives in exactly the cycle the sweep is clearing that same frame.

The bench reaches it in four steps:
- It first marks every frame as used.
- It starts a loose search.
- It drives an access to frame pointer+1 during the first examination cycle.
- It checks the result: that frame must survive the first lap, so the victim moves one frame further and the latency grows to FRAMES+3 cycles.

The strict fallback is reached by writing every frame, so no clean unused frame exists for two laps. Random access mixes, with both policies, are checked against an arithmetic model of the sweep.

// File: rtl/clock_victim_pkg.sv
package clock_victim_pkg;
    typedef enum logic {
        SWP_IDLE  = 1'b0,
        SWP_SCAN  = 1'b1
    } sweep_state_e;
endpackage

// File: rtl/cvs_flag_table.sv
module cvs_flag_table #(
    parameter int FRAMES = 16
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      set_en,
    input  logic [$clog2(FRAMES)-1:0] set_idx,
    input  logic                      set_dirty,
    input  logic                      clr_ref_en,
    input  logic [$clog2(FRAMES)-1:0] clr_ref_idx,
    input  logic                      clr_dirty_en,
    input  logic [$clog2(FRAMES)-1:0] clr_dirty_idx,
    output logic [FRAMES-1:0]         ref_bits,
    output logic [FRAMES-1:0]         dirty_bits
);
    localparam int IDX_W = $clog2(FRAMES);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(FRAMES - 1);

    logic [FRAMES-1:0] ref_d, ref_q;
    logic [FRAMES-1:0] dirty_d, dirty_q;
    logic              set_ok;

    assign set_ok = set_en && (set_idx <= LAST);

    // per-frame next value: a new access always beats a sweep clear
    for (genvar i = 0; i < FRAMES; i++) begin : g_frame
        logic hit_set, hit_cref, hit_cdirty;
        assign hit_set    = set_ok && (set_idx == IDX_W'(i));
        assign hit_cref   = clr_ref_en && (clr_ref_idx == IDX_W'(i));
        assign hit_cdirty = clr_dirty_en && (clr_dirty_idx == IDX_W'(i));
        always_comb begin
            ref_d[i]   = hit_set ? 1'b1 : (hit_cref ? 1'b0 : ref_q[i]);
            dirty_d[i] = (hit_set && set_dirty) ? 1'b1 :
                         (hit_cdirty ? 1'b0 : dirty_q[i]);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ref_q   <= '0;
            dirty_q <= '0;
        end else begin
            ref_q   <= ref_d;
            dirty_q <= dirty_d;
        end
    end

    assign ref_bits   = ref_q;
    assign dirty_bits = dirty_q;
endmodule

// File: rtl/cvs_sweep_ctrl.sv
module cvs_sweep_ctrl
    import clock_victim_pkg::*;
#(
    parameter int FRAMES = 16
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      repl_req,
    input  logic                      strict_clean,
    input  logic [FRAMES-1:0]         ref_bits,
    input  logic [FRAMES-1:0]         dirty_bits,
    output logic                      clr_ref_en,
    output logic [$clog2(FRAMES)-1:0] clr_ref_idx,
    output logic                      clr_dirty_en,
    output logic [$clog2(FRAMES)-1:0] clr_dirty_idx,
    output logic                      busy,
    output logic                      victim_done,
    output logic [$clog2(FRAMES)-1:0] victim_idx,
    output logic                      victim_dirty
);
    localparam int IDX_W  = $clog2(FRAMES);
    localparam int STEP_W = $clog2(2 * FRAMES + 1);
    localparam logic [IDX_W-1:0]  LAST      = IDX_W'(FRAMES - 1);
    localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(2 * FRAMES - 1);

    typedef struct packed {
        sweep_state_e      st;
        logic [IDX_W-1:0]  ptr;
        logic [IDX_W-1:0]  cur;
        logic [STEP_W-1:0] steps;
        logic              strict;
        logic              fb_v;
        logic [IDX_W-1:0]  fb_idx;
        logic              done;
        logic [IDX_W-1:0]  vic_idx;
        logic              vic_dirty;
    } sweep_regs_t;

    sweep_regs_t r_q, r_d;

    logic             cur_ref, cur_dirty, pick, pick_dirty;
    logic [IDX_W-1:0] cur_next, ptr_next, pick_idx;

    always_comb begin
        r_d           = r_q;
        r_d.done      = 1'b0;
        cur_ref       = ref_bits[r_q.cur];
        cur_dirty     = dirty_bits[r_q.cur];
        cur_next      = (r_q.cur == LAST) ? '0 : r_q.cur + 1'b1;
        ptr_next      = (r_q.ptr == LAST) ? '0 : r_q.ptr + 1'b1;
        pick          = 1'b0;
        pick_idx      = r_q.cur;
        pick_dirty    = cur_dirty;
        clr_ref_en    = 1'b0;
        clr_ref_idx   = r_q.cur;
        clr_dirty_en  = 1'b0;
        clr_dirty_idx = r_q.cur;
        unique case (r_q.st)
            SWP_IDLE: begin
                if (repl_req) begin
                    r_d.st     = SWP_SCAN;
                    r_d.cur    = ptr_next;
                    r_d.steps  = '0;
                    r_d.strict = strict_clean;
                    r_d.fb_v   = 1'b0;
                end
            end
            SWP_SCAN: begin
                clr_ref_en = cur_ref;
                if (!r_q.strict && !cur_ref) begin
                    pick = 1'b1;
                end else if (r_q.strict && !cur_ref && !cur_dirty) begin
                    pick = 1'b1;
                end else begin
                    if (r_q.strict && !r_q.fb_v && !cur_ref) begin
                        r_d.fb_v   = 1'b1;
                        r_d.fb_idx = r_q.cur;
                    end
                    if (r_q.strict && (r_q.steps == LAST_STEP)) begin
                        if (r_d.fb_v) begin
                            pick       = 1'b1;
                            pick_idx   = r_d.fb_idx;
                            pick_dirty = 1'b1;
                        end else begin
                            r_d.strict = 1'b0;
                        end
                    end
                    r_d.cur   = cur_next;
                    r_d.steps = r_q.steps + 1'b1;
                end
                if (pick) begin
                    r_d.st        = SWP_IDLE;
                    r_d.done      = 1'b1;
                    r_d.vic_idx   = pick_idx;
                    r_d.vic_dirty = pick_dirty;
                    r_d.ptr       = pick_idx;
                    clr_dirty_en  = 1'b1;
                    clr_dirty_idx = pick_idx;
                end
            end
            default: r_d.st = SWP_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q     <= '0;
            r_q.st  <= SWP_IDLE;
            r_q.ptr <= LAST;
        end else begin
            r_q <= r_d;
        end
    end

    assign busy         = (r_q.st == SWP_SCAN);
    assign victim_done  = r_q.done;
    assign victim_idx   = r_q.vic_idx;
    assign victim_dirty = r_q.vic_dirty;
endmodule

// File: rtl/clock_victim_sel.sv
module clock_victim_sel #(
    parameter int FRAMES = 16
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      acc_valid,
    input  logic [$clog2(FRAMES)-1:0] acc_idx,
    input  logic                      acc_write,
    input  logic                      repl_req,
    input  logic                      strict_clean,
    output logic                      busy,
    output logic                      victim_done,
    output logic [$clog2(FRAMES)-1:0] victim_idx,
    output logic                      victim_dirty
);
    localparam int IDX_W = $clog2(FRAMES);

    logic [FRAMES-1:0] ref_bits;
    logic [FRAMES-1:0] dirty_bits;
    logic              clr_ref_en, clr_dirty_en;
    logic [IDX_W-1:0]  clr_ref_idx, clr_dirty_idx;

    cvs_flag_table #(.FRAMES(FRAMES)) u_flags (
        .clk           (clk),
        .rst_n         (rst_n),
        .set_en        (acc_valid),
        .set_idx       (acc_idx),
        .set_dirty     (acc_write),
        .clr_ref_en    (clr_ref_en),
        .clr_ref_idx   (clr_ref_idx),
        .clr_dirty_en  (clr_dirty_en),
        .clr_dirty_idx (clr_dirty_idx),
        .ref_bits      (ref_bits),
        .dirty_bits    (dirty_bits)
    );

    cvs_sweep_ctrl #(.FRAMES(FRAMES)) u_sweep (
        .clk           (clk),
        .rst_n         (rst_n),
        .repl_req      (repl_req),
        .strict_clean  (strict_clean),
        .ref_bits      (ref_bits),
        .dirty_bits    (dirty_bits),
        .clr_ref_en    (clr_ref_en),
        .clr_ref_idx   (clr_ref_idx),
        .clr_dirty_en  (clr_dirty_en),
        .clr_dirty_idx (clr_dirty_idx),
        .busy          (busy),
        .victim_done   (victim_done),
        .victim_idx    (victim_idx),
        .victim_dirty  (victim_dirty)
    );
endmodule

// File: rtl/clock_victim_sel_chk.sv
module clock_victim_sel_chk #(
    parameter int FRAMES = 16
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      acc_valid,
    input logic [$clog2(FRAMES)-1:0] acc_idx,
    input logic                      acc_write,
    input logic                      repl_req,
    input logic                      busy,
    input logic                      victim_done,
    input logic [$clog2(FRAMES)-1:0] victim_idx,
    input logic [FRAMES-1:0]         ref_bits,
    input logic [FRAMES-1:0]         dirty_bits
);
    localparam int IDX_W = $clog2(FRAMES);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(FRAMES - 1);

    assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        victim_done |=> !victim_done);

    assert_start_on_req_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(repl_req));

    assert_done_after_scan_R5: assert property (@(posedge clk) disable iff (!rst_n)
        victim_done |-> $past(busy));

    assert_victim_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
        victim_done |-> (victim_idx <= LAST));

    assert_access_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && (acc_idx <= LAST)) |=> ref_bits[$past(acc_idx)]);

    assert_write_marks_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_write && (acc_idx <= LAST)) |=> dirty_bits[$past(acc_idx)]);

    assert_victim_cleaned_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (victim_done && !$past(acc_valid && acc_write && (acc_idx == victim_idx)))
        |-> !dirty_bits[victim_idx]);
endmodule

bind clock_victim_sel clock_victim_sel_chk #(.FRAMES(FRAMES)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .acc_valid   (acc_valid),
    .acc_idx     (acc_idx),
    .acc_write   (acc_write),
    .repl_req    (repl_req),
    .busy        (busy),
    .victim_done (victim_done),
    .victim_idx  (victim_idx),
    .ref_bits    (ref_bits),
    .dirty_bits  (dirty_bits)
);

// File: tb/sim_clock_victim_sel.sv
module sim_clock_victim_sel;
    localparam int NF = 6;
    localparam int IW = $clog2(NF);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          acc_valid = 1'b0;
    logic [IW-1:0] acc_idx = '0;
    logic          acc_write = 1'b0;
    logic          repl_req = 1'b0;
    logic          strict_clean = 1'b0;
    logic          busy, victim_done, victim_dirty;
    logic [IW-1:0] victim_idx;

    clock_victim_sel #(.FRAMES(NF)) u0 (
        .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_idx(acc_idx),
        .acc_write(acc_write), .repl_req(repl_req), .strict_clean(strict_clean),
        .busy(busy), .victim_done(victim_done), .victim_idx(victim_idx),
        .victim_dirty(victim_dirty)
    );

    always #2 clk = ~clk;

    int n_chk = 0;
    int n_bad = 0;
    bit mref[NF];
    bit mdirty[NF];
    int mptr;
    int unsigned seed = 32'h1234_5678;

    task automatic chk(input string tag, input int got, input int exp);
        n_chk++;
        if (got != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, got, exp);
        end
    endtask

    function automatic int unsigned rnd();
        seed ^= seed << 13;
        seed ^= seed >> 17;
        seed ^= seed << 5;
        return seed;
    endfunction

    // arithmetic model of the sweep, from the requirements
    task automatic model_req(input bit strict, output int eidx, output int edirty, output int elat);
        int  cur = (mptr + 1) % NF;
        bit  st = strict;
        bit  fbv = 1'b0;
        int  fbi = 0;
        int  ex = 0;
        eidx = -1; edirty = 0;
        while (eidx < 0 && ex < 4 * NF) begin
            bit r = mref[cur];
            bit d = mdirty[cur];
            ex++;
            if (!st && !r) begin eidx = cur; edirty = d; end
            else if (st && !r && !d) begin eidx = cur; edirty = 0; end
            else begin
                if (r) mref[cur] = 1'b0;
                if (st && !fbv && !r) begin fbv = 1'b1; fbi = cur; end
                if (st && ex == 2 * NF) begin
                    if (fbv) begin eidx = fbi; edirty = 1; end
                    else st = 1'b0;
                end
                cur = (cur + 1) % NF;
            end
        end
        elat = ex + 1;
        mptr = eidx;
        mdirty[eidx] = 1'b0;
    endtask

    task automatic do_acc(input int idx, input bit wr);
        @(negedge clk);
        acc_valid = 1'b1; acc_idx = IW'(idx); acc_write = wr;
        @(negedge clk);
        acc_valid = 1'b0; acc_write = 1'b0;
        mref[idx] = 1'b1;
        if (wr) mdirty[idx] = 1'b1;
    endtask

    task automatic do_req(input bit strict, input bit inject, input int inj_idx,
                          input bit dup, output int vidx, output int vd, output int lat);
        @(negedge clk);
        repl_req = 1'b1; strict_clean = strict;
        @(negedge clk);
        repl_req = dup;
        lat = 1;
        chk("R10 busy after accept", busy, 1);
        if (inject) begin
            acc_valid = 1'b1; acc_idx = IW'(inj_idx); acc_write = 1'b0;
        end
        do begin
            @(negedge clk);
            repl_req = 1'b0; acc_valid = 1'b0;
            lat++;
        end while (!victim_done && lat < 200);
        if (!victim_done) chk("R5 done timeout", 0, 1);
        vidx = victim_idx; vd = victim_dirty;
    endtask

    task automatic req_vs_model(input bit strict, input string tag);
        int ei, ed, el, gi, gd, gl;
        do_req(strict, 1'b0, 0, 1'b0, gi, gd, gl);
        model_req(strict, ei, ed, el);
        chk({tag, " victim"}, gi, ei);
        chk({tag, " dirty flag"}, gd, ed);
        chk({tag, " R5 latency"}, gl, el);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        int gi, gd, gl, p, v;
        for (int i = 0; i < NF; i++) begin mref[i] = 1'b0; mdirty[i] = 1'b0; end
        mptr = NF - 1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 busy after reset", busy, 0);
        chk("R1 done after reset", victim_done, 0);
        do_req(1'b0, 1'b0, 0, 1'b0, gi, gd, gl);
        chk("R1 first victim", gi, 0);
        chk("R1 first latency", gl, 2);
        chk("R11 first dirty", gd, 0);
        mptr = 0;

        // R2 R3 R4 R6 R7 R11: random mixes against the model
        for (int round = 0; round < 120; round++) begin
            int na = int'(rnd() % 5);
            for (int a = 0; a < na; a++)
                do_acc(int'(rnd() % NF), bit'(rnd() % 2));
            req_vs_model(bit'(rnd() % 2), (round % 2 == 0) ? "R3 R4 mix" : "R6 R11 mix");
        end

        // R7: every frame written, no clean unused frame for two laps
        for (int i = 0; i < NF; i++) do_acc(i, 1'b1);
        p = mptr;
        do_req(1'b1, 1'b0, 0, 1'b0, gi, gd, gl);
        chk("R7 fallback victim", gi, (p + 1) % NF);
        chk("R7 fallback dirty flag", gd, 1);
        chk("R7 fallback latency", gl, 2 * NF + 1);
        for (int i = 0; i < NF; i++) mref[i] = 1'b0;
        mptr = (p + 1) % NF; mdirty[mptr] = 1'b0;

        // R6: the only clean frame is the last victim
        v = mptr;
        do_req(1'b1, 1'b0, 0, 1'b0, gi, gd, gl);
        chk("R6 clean victim", gi, v);
        chk("R6 dirty flag", gd, 0);
        chk("R6 latency", gl, NF + 1);

        // R8: access collides with the sweep clear of the first examined frame
        for (int i = 0; i < NF; i++) do_acc(i, 1'b0);
        p = mptr;
        do_req(1'b0, 1'b1, (p + 1) % NF, 1'b0, gi, gd, gl);
        chk("R8 victim after collision", gi, (p + 2) % NF);
        chk("R8 latency", gl, NF + 3);
        chk("R8 R11 dirty flag", gd, int'(mdirty[(p + 2) % NF]));
        for (int i = 0; i < NF; i++) mref[i] = 1'b0;
        mptr = (p + 2) % NF; mdirty[mptr] = 1'b0;

        // R10: extra request while busy is ignored
        for (int i = 0; i < NF; i++) do_acc(i, 1'b0);
        p = mptr;
        do_req(1'b0, 1'b0, 0, 1'b1, gi, gd, gl);
        chk("R10 victim", gi, (p + 1) % NF);
        chk("R10 R5 full-lap latency", gl, NF + 2);
        for (int i = 0; i < NF; i++) mref[i] = 1'b0;
        mptr = (p + 1) % NF; mdirty[mptr] = 1'b0;
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            chk("R10 no second done", victim_done, 0);
            chk("R10 idle after done", busy, 0);
        end
        // R4: pointer unaffected by the ignored request
        req_vs_model(1'b0, "R4 after ignored request");

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule